// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is an I2C target that fronts a byte-addressable memory of 256 B to 2 KB held in an internal register array. A master addresses it with a select byte. The top nibble must be 1010b. The next three bits are matched against three strap pins, and the last bit chooses read or write. As the capacity parameter grows, those three select bits stop being compared one by one. They become the high memory address bits instead.

Writes go through a 16-byte page buffer. A stop that ends a write with accepted data starts a timed internal write cycle. During that cycle the slave ignores the bus, and when the cycle ends the buffered bytes are committed to the array. Reads come in three forms: from the current address counter, from an address loaded by a preceding write-mode header, or as a sequential run. The slave drives SDA only through an open-drain enable. SCL and SDA are synchronized to the system clock and oversampled there.

Top module: `i2cee_slave`

## Requirements
- R1: After reset the SDA pull-down enable is low and the slave is in standby.
- R2: A select byte is accepted only if bits 7..4 equal 1010b and every select bit 3..1 (E2,E1,E0) that is still compared equals the strap (bit 3 to strap 2, bit 1 to strap 0). An accepted select is acknowledged by pulling SDA low during the 9th clock. A rejected select is not acknowledged, and the slave stays silent until the next start.
- R3: With capacity 512 B, 1 KB or 2 KB, select bit 1 (E0), then bit 2 (E1), then bit 3 (E2) become address bits A8, A9 and A10 and are not compared. At 1 KB, E1 and E0 give A9 and A8 and only E2 is compared.
- R4: In a write, the byte after the select is the low address byte. Each following data byte is stored at the next address, and the offset wraps within the aligned 16-byte page. The bytes reach the array only when the write cycle ends.
- R5: A stop after at least one accepted data byte starts a busy period of WR_CYCLES system clocks. While it runs, every select is left unacknowledged. After it ends, the committed data reads back.
- R6: While the write-control input is high, the select and address bytes are acknowledged, data bytes are not, nothing is stored, and no busy period starts.
- R7: A write-mode select and an address byte, followed by a repeated start and a read-mode select, return the byte at that address, most significant bit first.
- R8: A read-mode select alone returns the byte at the address that follows the last byte transferred.
- R9: When the master acknowledges a read byte, the next address follows. The address wraps from the last array location to 0.
- R10: A master no-acknowledge ends the read. After the following stop the slave releases SDA and does not drive it on later clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| ce_i | input | 3 | Chip-enable straps (bit 2 = E2 ... bit 0 = E0) |
| wc_i | input | 1 | Write control; high blocks writes |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The end of the write cycle and the detection of a new start can fall in the same system clock. The slave must still treat that start as ignored and must commit the page exactly once. The bench provokes this by acknowledge polling right after a page write that wraps inside its page. It sends select bytes back to back, so the polls sweep across the end of the busy window. It judges the result by three things: the first poll is rejected, a later poll is accepted, and every wrapped page byte reads back with its value, with none lost or written twice.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADR,
    ST_WR,
    ST_RD,
    ST_BUSY
  } ctl_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2cee_sync.sv
module i2cee_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic rst_sn,
  output logic scl_s,
  output logic sda_s,
  output logic wc_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [1:0] rst_q;
  logic [2:0] meta_q, sync_q, prev_q;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  // bit 0 scl, bit 1 sda, bit 2 write control; all idle high
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      meta_q <= 3'b111;
      sync_q <= 3'b111;
      prev_q <= 3'b111;
    end else begin
      meta_q <= {wc_i, sda_i, scl_i};
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign scl_s    = sync_q[0];
  assign sda_s    = sync_q[1];
  assign wc_s     = sync_q[2];
  assign scl_rise = sync_q[0] & ~prev_q[0];
  assign scl_fall = ~sync_q[0] & prev_q[0];
  assign start_ev = sync_q[0] & prev_q[0] & prev_q[1] & ~sync_q[1];
  assign stop_ev  = sync_q[0] & prev_q[0] & ~prev_q[1] & sync_q[1];

endmodule

// File: rtl/i2cee_wbuf.sv
module i2cee_wbuf #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       buf_we_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_off_i,
  input  logic [7:0]                 buf_data_i,
  input  logic                       buf_clr_i,
  input  logic                       commit_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o,
  output logic                       has_data_o
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [7:0]            mem_q  [DEPTH];
  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (buf_clr_i || commit_i) vld_d = '0;
    if (buf_we_i)              vld_d[buf_off_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (buf_we_i) pbuf_q[buf_off_i] <= buf_data_i;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit_i && vld_q[i]) mem_q[{page_i, OFF_W'(i)}] <= pbuf_q[i];
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign has_data_o = |vld_q;

  // R4
  commit_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (vld_q != '0));

  // R5
  no_store_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> !buf_we_i);

endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_s_i,
  input  logic                       sda_s_i,
  input  logic                       wc_s_i,
  input  logic                       rise_i,
  input  logic                       fall_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic [2:0]                 ce_i,
  input  logic [7:0]                 rd_data_i,
  input  logic                       has_data_i,
  output logic                       sda_oe_o,
  output logic                       buf_we_o,
  output logic [$clog2(PAGE_BYTES)-1:0] buf_off_o,
  output logic [7:0]                 buf_data_o,
  output logic                       buf_clr_o,
  output logic                       commit_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic [ADDR_W-1:0]          addr_o
);

  localparam int         OFF_W    = $clog2(PAGE_BYTES);
  localparam int         EXTRA    = ADDR_W - 8;
  localparam logic [2:0] CMP_MASK = 3'b111 << EXTRA;
  localparam int         CNT_W    = $clog2(WR_CYCLES + 1);

  ctl_state_e        state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d, tx_q, tx_d;
  logic              ack_q, ack_d, oe_q, oe_d, rw_q, rw_d;
  logic [2:0]        hi_q, hi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        byte_in;
  logic              sel_ok;

  assign byte_in = {sh_q[6:0], sda_s_i};
  assign sel_ok  = (byte_in[7:4] == DEV_TYPE) &&
                   (((byte_in[3:1] ^ ce_i) & CMP_MASK) == 3'b000);

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    ack_d     = ack_q;
    oe_d      = oe_q;
    rw_d      = rw_q;
    hi_d      = hi_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    buf_we_o  = 1'b0;
    buf_clr_o = 1'b0;
    commit_o  = 1'b0;
    if (state_q == ST_BUSY) begin
      oe_d = 1'b0;
      if (cnt_q == '0) begin
        commit_o = 1'b1;
        state_d  = ST_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start_i) begin
      state_d   = ST_DEV;
      bit_d     = 4'd0;
      oe_d      = 1'b0;
      buf_clr_o = 1'b1;
    end else if (stop_i) begin
      oe_d = 1'b0;
      if (state_q == ST_WR && has_data_i) begin
        state_d = ST_BUSY;
        cnt_d   = CNT_W'(WR_CYCLES - 1);
      end else begin
        state_d = ST_IDLE;
      end
    end else if (state_q != ST_IDLE) begin
      if (rise_i) begin
        if (bit_q < 4'd8) begin
          sh_d  = byte_in;
          bit_d = bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            case (state_q)
              ST_DEV: begin
                if (sel_ok) begin
                  ack_d = 1'b1;
                  rw_d  = byte_in[0];
                  hi_d  = byte_in[3:1];
                end else begin
                  ack_d   = 1'b0;
                  state_d = ST_IDLE;
                end
              end
              ST_ADR: begin
                ack_d  = 1'b1;
                addr_d = ADDR_W'({hi_q, byte_in});
              end
              ST_WR: begin
                if (!wc_s_i) begin
                  ack_d    = 1'b1;
                  buf_we_o = 1'b1;
                  addr_d   = {addr_q[ADDR_W-1:OFF_W], addr_q[OFF_W-1:0] + 1'b1};
                end else begin
                  ack_d = 1'b0;
                end
              end
              ST_RD: begin
                ack_d  = 1'b0;
                addr_d = addr_q + 1'b1;
              end
              default: ;
            endcase
          end
        end else begin
          bit_d = 4'd9;
          if (state_q == ST_RD && sda_s_i) state_d = ST_IDLE;
        end
      end else if (fall_i) begin
        if (bit_q == 4'd8) begin
          oe_d = ack_q;
        end else if (bit_q == 4'd9) begin
          bit_d = 4'd0;
          oe_d  = 1'b0;
          case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_d = ST_RD;
                tx_d    = rd_data_i;
                oe_d    = ~rd_data_i[7];
              end else begin
                state_d = ST_ADR;
              end
            end
            ST_ADR: state_d = ST_WR;
            ST_RD: begin
              tx_d = rd_data_i;
              oe_d = ~rd_data_i[7];
            end
            default: ;
          endcase
        end else if (state_q == ST_RD && bit_q != 4'd0) begin
          oe_d = ~tx_q[6];
          tx_d = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= 4'd0;
      sh_q    <= 8'h00;
      tx_q    <= 8'h00;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      hi_q    <= 3'b000;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      hi_q    <= hi_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign buf_off_o  = addr_q[OFF_W-1:0];
  assign buf_data_o = byte_in;
  assign page_o     = addr_q[ADDR_W-1:OFF_W];
  assign addr_o     = addr_q;

  // R2
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s_i);

  // R10
  standby_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);

  // R5
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && start_i) |=> (state_q != ST_DEV));

  // R5
  busy_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_BUSY) |-> has_data_i);

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= 4'd9);

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave #(
  parameter int CAP_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] ce_i,
  input  logic       wc_i,
  output logic       sda_oe_o
);

  localparam int ADDR_W = $clog2(CAP_BYTES);
  localparam int OFF_W  = $clog2(PAGE_BYTES);

  logic              rst_sn, scl_s, sda_s, wc_s;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              buf_we, buf_clr, commit, has_data;
  logic [OFF_W-1:0]  buf_off;
  logic [7:0]        buf_data, rd_data;
  logic [ADDR_W-OFF_W-1:0] page;
  logic [ADDR_W-1:0] addr;

  i2cee_sync i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .wc_i     (wc_i),
    .rst_sn   (rst_sn),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .wc_s     (wc_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cee_ctrl #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .wc_s_i     (wc_s),
    .rise_i     (scl_rise),
    .fall_i     (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .ce_i       (ce_i),
    .rd_data_i  (rd_data),
    .has_data_i (has_data),
    .sda_oe_o   (sda_oe_o),
    .buf_we_o   (buf_we),
    .buf_off_o  (buf_off),
    .buf_data_o (buf_data),
    .buf_clr_o  (buf_clr),
    .commit_o   (commit),
    .page_o     (page),
    .addr_o     (addr)
  );

  i2cee_wbuf #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_wbuf (
    .clk        (clk),
    .rst_n      (rst_sn),
    .buf_we_i   (buf_we),
    .buf_off_i  (buf_off),
    .buf_data_i (buf_data),
    .buf_clr_i  (buf_clr),
    .commit_i   (commit),
    .page_i     (page),
    .rd_addr_i  (addr),
    .rd_data_o  (rd_data),
    .has_data_o (has_data)
  );

endmodule

// File: tb/test_i2cee_slave.sv
module test_i2cee_slave;

  localparam int Q   = 5;
  localparam int WRC = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       wc = 1'b0;
  logic [2:0] ce = 3'b100;
  logic       sda_oe;
  logic       sda_line;
  logic [7:0] rbuf [16];
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2cee_slave #(.CAP_BYTES(1024), .PAGE_BYTES(16), .WR_CYCLES(WRC)) i_i2cee_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .ce_i     (ce),
    .wc_i     (wc),
    .sda_oe_o (sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    b = sda_line; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] sel(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b1, a[9:8], rd};
  endfunction

  task automatic wait_cycle();
    repeat (WRC + 50) @(negedge clk);
  endtask

  task automatic do_write(input string req, input logic [9:0] a, input int n,
                          input logic [7:0] base, input logic [7:0] step,
                          input logic exp_dack);
    logic ack;
    bus_start();
    send_byte(sel(a, 1'b0), ack);
    chk({req, " write select ack"}, ack, 1);
    send_byte(a[7:0], ack);
    chk({req, " address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(8'(base + 8'(i) * step), ack);
      chk({req, " data ack"}, ack, exp_dack);
    end
    bus_stop();
  endtask

  task automatic do_read(input string req, input logic [9:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(sel(a, 1'b0), ack);
    chk({req, " read header ack"}, ack, 1);
    send_byte(a[7:0], ack);
    chk({req, " read address ack"}, ack, 1);
    bus_restart();
    send_byte(sel(a, 1'b1), ack);
    chk({req, " read select ack"}, ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 line idle", sda_line, 1);
  endtask

  task automatic t_select();
    logic ack;
    bus_start();
    send_byte(8'b1010_0000, ack);     // E2 = 0 while strap 2 is 1
    chk("R2 strap mismatch nack", ack, 0);
    send_byte(8'h00, ack);            // no start: must stay silent
    chk("R2 silent until start", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB8, ack);            // wrong type nibble
    chk("R2 type mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA8, ack);
    chk("R2 match ack", ack, 1);
    bus_stop();
  endtask

  task automatic t_byte_write();
    do_write("R4", 10'h155, 2, 8'h3C, 8'h87, 1'b1);  // 0x155=3C, 0x156=C3
    wait_cycle();
    do_write("R3", 10'h055, 1, 8'h77, 8'h00, 1'b1);
    wait_cycle();
    do_read("R7", 10'h155, 1);
    chk("R7 random read 0x155", rbuf[0], 8'h3C);
    do_read("R3", 10'h055, 1);
    chk("R3 select bits as A9A8", rbuf[0], 8'h77);
  endtask

  task automatic t_current();
    logic ack;
    do_read("R8", 10'h155, 1);
    bus_start();
    send_byte(sel(10'h000, 1'b1), ack);
    chk("R8 current select ack", ack, 1);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    chk("R8 current read 0x156", rbuf[0], 8'hC3);
  endtask

  task automatic t_wc();
    wc = 1'b1; qwait();
    do_write("R6", 10'h155, 1, 8'h00, 8'h00, 1'b0);
    wc = 1'b0; qwait();
    do_read("R6", 10'h155, 1);       // select ack here proves no busy period
    chk("R6 data unchanged", rbuf[0], 8'h3C);
  endtask

  task automatic t_page();
    logic ack;
    int   polls;
    do_write("R4", 10'h2F8, 10, 8'h10, 8'h03, 1'b1);
    bus_start();
    send_byte(sel(10'h2F8, 1'b0), ack);
    bus_stop();
    chk("R5 select during busy nack", ack, 0);
    polls = 1;
    ack = 1'b0;
    while (!ack && polls < 10) begin
      bus_start();
      send_byte(sel(10'h2F8, 1'b0), ack);
      bus_stop();
      polls++;
    end
    chk("R5 ack after busy", ack, 1);
    do_read("R5", 10'h2F8, 8);
    for (int i = 0; i < 8; i++)
      chk("R5 committed page byte", rbuf[i], 8'(8'h10 + 8'(i) * 8'h03));
    do_read("R4", 10'h2F0, 2);
    chk("R4 page wrap byte 0x2F0", rbuf[0], 8'h28);
    chk("R4 page wrap byte 0x2F1", rbuf[1], 8'h2B);
  endtask

  task automatic t_wrap();
    do_write("R9", 10'h3FF, 1, 8'hA5, 8'h00, 1'b1);
    wait_cycle();
    do_write("R9", 10'h000, 1, 8'h5A, 8'h00, 1'b1);
    wait_cycle();
    do_read("R9", 10'h3FF, 2);
    chk("R9 last location", rbuf[0], 8'hA5);
    chk("R9 wrap to 0", rbuf[1], 8'h5A);
  endtask

  task automatic t_standby();
    logic b;
    int   lows = 0;
    do_read("R10", 10'h155, 1);
    for (int i = 0; i < 18; i++) begin
      get_bit(b);
      if (!b) lows++;
    end
    chk("R10 bus released after nack and stop", lows, 0);
    chk("R10 oe low", sda_oe, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_select();
    t_byte_write();
    t_current();
    t_wc();
    t_page();
    t_wrap();
    t_standby();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule